// File: doc/BRIEF.md
# Reflected CRC-8 Byte Checker

This block keeps a running 8-bit cyclic redundancy check over a stream of bytes, the kind used to protect identity codes and scratch data on single-wire sensor buses. Each clock that carries a valid byte folds that byte into the running value in one step. The generator is x^8+x^5+x^4+1, applied in reflected form (constant 0x8C, data consumed least-significant bit first).

A receiver clears the block before a block of data and then strobes in every byte, including the CRC byte that the sender appended. When the block arrived intact, the running value returns to zero, and a registered flag reports this. A parameter selects how the byte update is built: a chain of eight single-bit steps, or a 256-entry lookup whose contents are computed at elaboration. Both forms give identical results.

Top module: `crc8_checker`

## Requirements
- R1: After reset the CRC output is 0x00 and the zero flag is 1.
- R2: On a cycle with valid high and clear low, the next CRC is F(old CRC XOR data), where F(x) applies eight times: shift right by one, and XOR with 0x8C if the bit shifted out was 1.
- R3: Starting from 0x00, a single byte gives these results: 0x00 gives 0x00, 0x01 gives 0x5E, 0x02 gives 0xBC, 0x03 gives 0xE2, 0x80 gives 0x8C, 0xFF gives 0x35.
- R4: On a cycle with both valid and clear low, the CRC and the zero flag keep their values, whatever the data input carries.
- R5: Clear high sets the CRC to 0x00 on the next edge and wins over valid in the same cycle.
- R6: The zero flag is 1 exactly when the registered CRC is 0x00, so a block followed by its own CRC byte leaves the flag at 1.
- R7: Bytes may arrive on consecutive cycles for any block length, with one update per byte and the result visible one cycle after each strobe.
- R8: The bit-chain build (USE_TABLE=0) and the lookup build (USE_TABLE=1) produce the same CRC and flag for every input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the running CRC |
| valid_i | input | 1 | Byte strobe; data_i is folded in when high |
| data_i | input | 8 | Data byte |
| crc_o | output | 8 | Registered running CRC |
| crc_zero_o | output | 1 | High when the running CRC is 0x00 |

## Verification
Single bytes from a cleared state hit the six fixed results that pin the reflected 0x8C form, which a non-reflected or MSB-first update would miss. Random blocks of random length are streamed back to back and then closed with their own CRC byte, which separates a correct per-byte chain from one that drops or repeats a byte and shows the flag rising only at the end. Idle cycles with changing data and clear colliding with a strobe show that the hold and the clear priority are right. Both build variants run side by side on the same stimulus so that any difference between them shows up.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned TBL_DEPTH = 1 << BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t crc;
        logic  zero;
    } crc_state_t;

    // Fold a full byte of zeros through the reflected register (used to build the lookup).
    function automatic byte_t crc_fold_byte(input byte_t seed, input byte_t poly);
        byte_t c;
        c = seed;
        for (int i = 0; i < BYTE_W; i++) begin
            c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/crc8_bit_step.sv
module crc8_bit_step
    import crc8_pkg::*;
#(
    parameter byte_t POLY = 8'h8C
) (
    input  byte_t crc_in,
    input  logic  bit_in,
    output byte_t crc_out
);
    logic mix;

    always_comb begin
        mix     = crc_in[0] ^ bit_in;
        crc_out = (crc_in >> 1) ^ (mix ? POLY : '0);
    end
endmodule

// File: rtl/crc8_byte_update.sv
module crc8_byte_update
    import crc8_pkg::*;
#(
    parameter byte_t POLY      = 8'h8C,
    parameter bit    USE_TABLE = 1'b0
) (
    input  byte_t crc_in,
    input  byte_t data_in,
    output byte_t crc_out
);
    if (USE_TABLE) begin : g_table
        byte_t tbl [TBL_DEPTH];
        byte_t idx;

        for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_entry
            assign tbl[g] = crc_fold_byte(byte_t'(g), POLY);
        end

        assign idx     = crc_in ^ data_in;
        assign crc_out = tbl[idx];
    end else begin : g_chain
        byte_t stage [BYTE_W+1];

        assign stage[0] = crc_in;

        for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
            crc8_bit_step #(.POLY(POLY)) u_step (
                .crc_in (stage[b]),
                .bit_in (data_in[b]),
                .crc_out(stage[b+1])
            );
        end

        assign crc_out = stage[BYTE_W];
    end
endmodule

// File: rtl/crc8_checker.sv
module crc8_checker
    import crc8_pkg::*;
#(
    parameter byte_t POLY      = 8'h8C,
    parameter bit    USE_TABLE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       valid_i,
    input  logic [7:0] data_i,
    output logic [7:0] crc_o,
    output logic       crc_zero_o
);
    localparam byte_t CRC_INIT = '0;

    crc_state_t st_d, st_q;
    byte_t      upd_crc;

    crc8_byte_update #(
        .POLY     (POLY),
        .USE_TABLE(USE_TABLE)
    ) u_update (
        .crc_in (st_q.crc),
        .data_in(data_i),
        .crc_out(upd_crc)
    );

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.crc = CRC_INIT;
        end else if (valid_i) begin
            st_d.crc = upd_crc;
        end
        st_d.zero = (st_d.crc == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{crc: CRC_INIT, zero: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_o      = st_q.crc;
    assign crc_zero_o = st_q.zero;

    // Clear wins over a strobe and lands a zero CRC on the next edge.
    assert_clear_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (crc_o == 8'h00));

    // Without clear or strobe the state is frozen.
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !valid_i) |=> ($stable(crc_o) && $stable(crc_zero_o)));

    // The registered flag tracks the registered CRC.
    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_zero_o == (crc_o == 8'h00));

    // Feeding the current CRC as data cancels it: the update of zero is zero.
    assert_self_cancel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && valid_i && data_i == crc_o) |=> crc_zero_o);

endmodule

// File: tb/tb_crc8_checker.sv
module tb_crc8_checker;

    logic       clk;
    logic       rst_n;
    logic       clear;
    logic       valid;
    logic [7:0] data;
    logic [7:0] crc_a, crc_b;
    logic       zero_a, zero_b;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [7:0] model = 8'h00;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    crc8_checker #(.USE_TABLE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .valid_i(valid),
        .data_i(data), .crc_o(crc_a), .crc_zero_o(zero_a)
    );

    crc8_checker #(.USE_TABLE(1'b1)) dut_tbl (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .valid_i(valid),
        .data_i(data), .crc_o(crc_b), .crc_zero_o(zero_b)
    );

    // Reference: reflected 0x8C, LSB first, per the requirement text.
    function automatic logic [7:0] ref_update(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 8'h8C;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [7:0] exp);
        checks++;
        if (crc_a !== exp || zero_a !== (exp == 8'h00)) begin
            errors++;
            $display("FAIL %s: bit-chain crc=%02h zero=%0b expected crc=%02h zero=%0b",
                     tag, crc_a, zero_a, exp, exp == 8'h00);
        end
        checks++;
        if (crc_b !== exp || zero_b !== (exp == 8'h00)) begin
            errors++;
            $display("FAIL %s (R8 lookup): crc=%02h zero=%0b expected crc=%02h zero=%0b",
                     tag, crc_b, zero_b, exp, exp == 8'h00);
        end
    endtask

    // Called at a falling edge; drives for one cycle and checks at the next falling edge.
    task automatic apply(input string tag, input logic c, input logic v, input logic [7:0] d);
        clear = c; valid = v; data = d;
        @(negedge clk);
        if (c)      model = 8'h00;
        else if (v) model = ref_update(model, d);
        check(tag, model);
    endtask

    initial begin
        logic [7:0] spot_in  [6];
        logic [7:0] spot_out [6];
        void'($urandom(32'd20240611));
        rst_n = 1'b0; clear = 1'b0; valid = 1'b0; data = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", 8'h00);

        // R3 fixed single-byte results
        spot_in  = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h80, 8'hFF};
        spot_out = '{8'h00, 8'h5E, 8'hBC, 8'hE2, 8'h8C, 8'h35};
        for (int k = 0; k < 6; k++) begin
            apply("R5 clear", 1'b1, 1'b0, 8'h00);
            clear = 1'b0; valid = 1'b1; data = spot_in[k];
            @(negedge clk);
            model = spot_out[k];
            check("R3 spot value", spot_out[k]);
        end

        // R2 random single updates from arbitrary state
        for (int k = 0; k < 40; k++) begin
            apply("R2 update", 1'b0, 1'b1, 8'($urandom));
        end

        // R4 idle with changing data
        for (int k = 0; k < 10; k++) begin
            apply("R4 hold", 1'b0, 1'b0, 8'($urandom));
        end

        // R5 clear together with a strobe
        apply("R5 clear beats strobe", 1'b1, 1'b1, 8'hA5);
        apply("R2 update after clear", 1'b0, 1'b1, 8'h3C);
        apply("R5 clear beats strobe", 1'b1, 1'b1, 8'h5A);

        // R7/R6 random blocks, back to back, closed by their CRC byte
        for (int blk = 0; blk < 60; blk++) begin
            int len;
            len = 1 + int'($urandom % 16);
            apply("R5 clear", 1'b1, 1'b0, 8'h00);
            for (int i = 0; i < len; i++) begin
                apply("R7 stream", 1'b0, 1'b1, 8'($urandom));
            end
            apply("R6 block closed by its CRC", 1'b0, 1'b1, model);
            if (blk % 4 == 0) begin
                apply("R4 hold after block", 1'b0, 1'b0, 8'hFF);
            end
        end

        // R6 corrupted block: wrong CRC byte leaves flag low
        apply("R5 clear", 1'b1, 1'b0, 8'h00);
        apply("R7 stream", 1'b0, 1'b1, 8'h28);
        apply("R7 stream", 1'b0, 1'b1, 8'h91);
        apply("R6 bad CRC byte", 1'b0, 1'b1, model ^ 8'h01);

        valid = 1'b0; clear = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule